// File: doc/BRIEF.md
# Keyboard Scan-Code Interrupt Controller

This block sits on a simple memory-mapped bus and collects 8-bit key codes that arrive from a keyboard receiver as a code byte plus a single-cycle valid strobe. Each arriving code is latched into a holding register, and a pending flag is raised. The pending flag is the only status bit the block keeps. It also drives the interrupt line to the processor, so software can either poll the flag or wait for the interrupt.

Software takes a code by reading the code location. That read returns the byte and retires the pending flag. An interrupt-return pulse from the processor also retires the flag. A soft-reset location, triggered by writing the value one, wipes the code and the flag without touching the bus read register. Reads are registered: the read data bus changes only on a clock edge that carries an accepted read, and it otherwise holds its last value. A synchronous active-low reset returns everything to zero.

Top module: `kbd_scan_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stored code, the pending flag and `bus_rdata` are all cleared to zero.
- R2: At a clock edge with `code_strobe` high, `code_byte` is stored as the current code and the pending flag is set.
- R3: A read (`bus_sel`=1, `bus_we`=0) of offset 0x00 loads `bus_rdata` at that edge with the code held before the edge, zero-extended to 32 bits, and clears the pending flag.
- R4: A high `irq_ack` at a clock edge clears the pending flag.
- R5: When `code_strobe` coincides with a flag-clearing read of 0x00 or with `irq_ack`, the flag stays set and the new byte is stored.
- R6: A read of offset 0x04 loads `bus_rdata` with the pending flag in bit 0 and zeros above, and leaves the flag unchanged.
- R7: A write (`bus_sel`=1, `bus_we`=1) of exactly 0x00000001 to offset 0x24 clears the stored code and the pending flag; any other data value written there has no effect.
- R8: When a soft-reset write coincides with `code_strobe`, the soft reset wins: the code and the flag end up zero.
- R9: Writes to offsets 0x00 and 0x04 change nothing, and on any edge without an accepted read of 0x00 or 0x04 (idle, unmapped offset, read of 0x24, any write) `bus_rdata` keeps its value.
- R10: `irq_o` always equals the pending flag, so it matches bit 0 returned by a read of 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request selecting this block |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Offset within the block, upper bits already zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, equals the pending flag |
| irq_ack | input | 1 | Interrupt-return pulse from the processor |
| code_byte | input | 8 | Key code from the receiver |
| code_strobe | input | 1 | One-cycle valid for `code_byte` |

## Verification
The collisions that matter are a new code arriving in the same cycle as something that retires or wipes the pending flag: a read of 0x00, an interrupt return, or a soft-reset write. Directed cycles put `code_strobe` exactly on the edge of each of these. A random phase then fires strobes, acknowledgements and bus accesses on independent draws, so the pairs also meet by chance. After each edge the flag is judged on `irq_o` and the code through a later read of 0x00, both against a bench model that applies the priority order soft reset, then strobe, then clear.

// File: rtl/kbd_irq_pkg.sv
// Package: shared offsets and decode type for the keyboard code controller.
// Assumes the bus presents a byte offset with the upper address bits zeroed.
package kbd_irq_pkg;

    // Register offsets inside the block's window.
    localparam int unsigned OFS_CODE  = 32'h0000_0000;
    localparam int unsigned OFS_FLAG  = 32'h0000_0004;
    localparam int unsigned OFS_WIPE  = 32'h0000_0024;

    // Data value that arms the soft reset.
    localparam int unsigned WIPE_KEY  = 32'h0000_0001;

    // Decoded access kinds for one bus cycle.
    typedef struct packed {
        logic rd_code;   // accepted read of the code location
        logic rd_flag;   // accepted read of the pending flag
        logic wipe;      // accepted soft-reset write
    } kbd_hit_t;

endpackage

// File: rtl/kbd_addr_decode.sv
// Module: bus access decoder.
// Turns one bus cycle into the three access kinds the block acts on.
// Assumes full-offset comparison; anything not matched is ignored.
module kbd_addr_decode
    import kbd_irq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output kbd_hit_t          hit
);

    localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(OFS_CODE);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_WIPE = ADDR_W'(OFS_WIPE);
    localparam logic [DATA_W-1:0] D_KEY  = DATA_W'(WIPE_KEY);

    logic rd_cyc;
    logic wr_cyc;

    // Split the request into read and write cycles.
    always_comb begin
        rd_cyc = bus_sel & ~bus_we;
        wr_cyc = bus_sel &  bus_we;
    end

    // Match offsets; write-only and read-only locations filter by direction.
    always_comb begin
        hit.rd_code = rd_cyc && (bus_addr == A_CODE);
        hit.rd_flag = rd_cyc && (bus_addr == A_FLAG);
        hit.wipe    = wr_cyc && (bus_addr == A_WIPE) && (bus_wdata == D_KEY);
    end

endmodule

// File: rtl/kbd_code_store.sv
// Module: code holding register and pending flag.
// Priority per edge: reset, soft reset, new code, clear request.
// Assumes the strobe is a single-cycle pulse per code.
module kbd_code_store #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              strobe,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              clr_req,
    output logic [CODE_W-1:0] code_q,
    output logic              pend_q
);

    // Hold the latest code; soft reset beats an arriving code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (wipe) begin
            code_q <= '0;
        end else if (strobe) begin
            code_q <= byte_in;
        end
    end

    // Pending flag; an arriving code beats any clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wipe) begin
            pend_q <= 1'b0;
        end else if (strobe) begin
            pend_q <= 1'b1;
        end else if (clr_req) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/kbd_rdata_reg.sv
// Module: registered read-data port.
// Loads only on an accepted read and holds otherwise.
// Assumes rd_code and rd_flag are never both set (distinct offsets).
module kbd_rdata_reg #(
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_code,
    input  logic              rd_flag,
    input  logic [CODE_W-1:0] code_q,
    input  logic              pend_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] code_ext;
    logic [DATA_W-1:0] flag_ext;

    // Zero-extend each source to the bus width.
    generate
        if (DATA_W > CODE_W) begin : g_pad
            always_comb code_ext = {{(DATA_W-CODE_W){1'b0}}, code_q};
        end else begin : g_trunc
            always_comb code_ext = code_q[DATA_W-1:0];
        end
    endgenerate

    // Flag occupies bit 0 only.
    always_comb flag_ext = {{(DATA_W-1){1'b0}}, pend_q};

    // Load on accepted read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_code) begin
            rdata_q <= code_ext;
        end else if (rd_flag) begin
            rdata_q <= flag_ext;
        end
    end

endmodule

// File: rtl/kbd_scan_irq_ctrl.sv
// Module: keyboard scan-code interrupt controller (top).
// Latches codes from a receiver, raises a pending flag that is also the
// interrupt, and exposes code, flag and soft reset on a registered bus port.
// Assumes a synchronous active-low reset and offsets with upper bits zero.
module kbd_scan_irq_ctrl
    import kbd_irq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    input  logic              irq_ack,
    input  logic [CODE_W-1:0] code_byte,
    input  logic              code_strobe
);

    kbd_hit_t          hit;
    logic [CODE_W-1:0] code_q;
    logic              pend_q;
    logic              clr_req;

    kbd_addr_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit       (hit)
    );

    // Either a code read or an interrupt return retires the flag.
    always_comb clr_req = hit.rd_code | irq_ack;

    kbd_code_store #(
        .CODE_W (CODE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (hit.wipe),
        .strobe  (code_strobe),
        .byte_in (code_byte),
        .clr_req (clr_req),
        .code_q  (code_q),
        .pend_q  (pend_q)
    );

    kbd_rdata_reg #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_code (hit.rd_code),
        .rd_flag (hit.rd_flag),
        .code_q  (code_q),
        .pend_q  (pend_q),
        .rdata_q (bus_rdata)
    );

    // Interrupt is the pending flag itself.
    always_comb irq_o = pend_q;

endmodule

// File: rtl/kbd_scan_irq_ctrl_chk.sv
// Module: protocol checker for the keyboard code controller, bound to the top.
// Observes ports only and judges flag and read-data behaviour over time.
module kbd_scan_irq_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              irq_ack,
    input logic              code_strobe
);

    logic rd0, rd4, wipe_wr;

    // Observer view of the bus cycle.
    always_comb begin
        rd0     = bus_sel && !bus_we && (bus_addr == ADDR_W'(32'h0));
        rd4     = bus_sel && !bus_we && (bus_addr == ADDR_W'(32'h4));
        wipe_wr = bus_sel &&  bus_we && (bus_addr == ADDR_W'(32'h24))
                  && (bus_wdata == DATA_W'(32'h1));
    end

    // R2
    strobe_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_strobe && !wipe_wr) |=> irq_o);

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !code_strobe && !wipe_wr) |=> !irq_o);

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !code_strobe) |=> !irq_o);

    // R6
    flag_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd4 |=> (bus_rdata == DATA_W'($past(irq_o))));

    // R8
    wipe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_wr |=> !irq_o);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd0 && !rd4) |=> $stable(bus_rdata));

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !code_strobe) |=> !irq_o);

endmodule

bind kbd_scan_irq_ctrl kbd_scan_irq_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .irq_ack     (irq_ack),
    .code_strobe (code_strobe)
);

// File: tb/tb_kbd_scan_irq_ctrl.sv
// Bench: directed corner cycles plus seeded random traffic, judged against
// a bench model of the requirements after every clock edge.
module tb_kbd_scan_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        irq_ack = 1'b0;
    logic [7:0]  code_byte = '0;
    logic        code_strobe = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model state
    logic [7:0]  m_code = '0;
    logic        m_flag = 1'b0;
    logic [31:0] m_rdata = '0;

    always #4 clk = ~clk;

    kbd_scan_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_o       (irq_o),
        .irq_ack     (irq_ack),
        .code_byte   (code_byte),
        .code_strobe (code_strobe)
    );

    function automatic logic [31:0] ext8(input logic [7:0] v);
        return {24'h0, v};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, advance model at posedge, sample after.
    task automatic cyc(input logic sel, input logic we, input logic [31:0] addr,
                       input logic [31:0] wd, input logic stb, input logic [7:0] b,
                       input logic ack, input string req);
        logic rd0, rd4, wipe;
        @(negedge clk);
        bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd;
        code_strobe = stb; code_byte = b; irq_ack = ack;
        rd0  = sel && !we && addr == 32'h0;
        rd4  = sel && !we && addr == 32'h4;
        wipe = sel && we && addr == 32'h24 && wd == 32'h1;
        @(posedge clk);
        if (!rst_n) begin
            m_code = '0; m_flag = 1'b0; m_rdata = '0;
        end else begin
            if (rd0)      m_rdata = ext8(m_code);
            else if (rd4) m_rdata = {31'h0, m_flag};
            if (wipe) begin
                m_code = '0; m_flag = 1'b0;
            end else if (stb) begin
                m_code = b; m_flag = 1'b1;
            end else if (rd0 || ack) begin
                m_flag = 1'b0;
            end
        end
        #1;
        chk({req, " rdata"}, bus_rdata, m_rdata);
        chk({req, " irq(R10)"}, {31'h0, irq_o}, {31'h0, m_flag});
    endtask

    task automatic idle(input string req);
        cyc(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 8'h0, 1'b0, req);
    endtask
    task automatic rd(input logic [31:0] a, input string req);
        cyc(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h0, 1'b0, req);
    endtask
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input string req);
        cyc(1'b1, 1'b1, a, d, 1'b0, 8'h0, 1'b0, req);
    endtask
    task automatic key(input logic [7:0] b, input string req);
        cyc(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, b, 1'b0, req);
    endtask

    function automatic logic [31:0] pick_addr(input int unsigned r);
        case (r % 6)
            0, 1:    return 32'h0;
            2:       return 32'h4;
            3:       return 32'h24;
            4:       return 32'h8;
            default: return 32'h0100_0000;
        endcase
    endfunction

    // Watchdog: a hang counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7731));
        // R1: reset with activity present
        rst_n = 1'b0;
        cyc(1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 8'hA5, 1'b0, "R1 reset");
        cyc(1'b1, 1'b0, 32'h4, 32'h0, 1'b1, 8'h5A, 1'b0, "R1 reset");
        rst_n = 1'b1;
        idle("R1 after reset");
        rd(32'h0, "R1 code zero");
        chk("R1 code after reset", bus_rdata, 32'h0);

        // R2 then R6 then R3
        key(8'h1C, "R2 strobe");
        rd(32'h4, "R6 flag read");
        chk("R6 flag bit", bus_rdata, 32'h1);
        chk("R6 flag kept", {31'h0, irq_o}, 32'h1);
        rd(32'h0, "R3 code read");
        chk("R3 code value", bus_rdata, 32'h1C);
        chk("R3 flag cleared", {31'h0, irq_o}, 32'h0);

        // R4 interrupt return
        key(8'hF0, "R2 strobe");
        cyc(1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 8'h0, 1'b1, "R4 ack");
        chk("R4 flag cleared", {31'h0, irq_o}, 32'h0);

        // R5 strobe with read, strobe with ack
        key(8'h11, "R5 setup");
        cyc(1'b1, 1'b0, 32'h0, 32'h0, 1'b1, 8'h22, 1'b0, "R5 read+strobe");
        chk("R5 old code returned", bus_rdata, 32'h11);
        chk("R5 flag kept", {31'h0, irq_o}, 32'h1);
        cyc(1'b0, 1'b0, 32'h0, 32'h0, 1'b1, 8'h33, 1'b1, "R5 ack+strobe");
        chk("R5 flag kept ack", {31'h0, irq_o}, 32'h1);
        rd(32'h0, "R5 new code");
        chk("R5 new code", bus_rdata, 32'h33);

        // R9 writes to read-only offsets ignored, unmapped read holds
        key(8'h44, "R9 setup");
        wr(32'h0, 32'hFF, "R9 write code");
        wr(32'h4, 32'h0, "R9 write flag");
        chk("R9 flag untouched", {31'h0, irq_o}, 32'h1);
        rd(32'h8, "R9 unmapped read");
        chk("R9 rdata held", bus_rdata, 32'h33);
        rd(32'h24, "R9 read of wipe");
        rd(32'h0, "R9 code untouched");
        chk("R9 code untouched", bus_rdata, 32'h44);

        // R7 soft reset: wrong key ignored, right key wipes
        key(8'h55, "R7 setup");
        wr(32'h24, 32'h2, "R7 wrong key");
        chk("R7 wrong key ignored", {31'h0, irq_o}, 32'h1);
        wr(32'h24, 32'h1, "R7 wipe");
        chk("R7 flag wiped", {31'h0, irq_o}, 32'h0);
        rd(32'h0, "R7 code wiped");
        chk("R7 code wiped", bus_rdata, 32'h0);

        // R8 soft reset beats strobe
        cyc(1'b1, 1'b1, 32'h24, 32'h1, 1'b1, 8'h77, 1'b0, "R8 wipe+strobe");
        chk("R8 flag zero", {31'h0, irq_o}, 32'h0);
        rd(32'h0, "R8 code zero");
        chk("R8 code zero", bus_rdata, 32'h0);

        // Random mix covering R2..R10 collisions
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom;
            logic sel = (r[3:0] < 4'd9);
            logic we  = r[4] & r[5];
            logic [31:0] a = pick_addr($urandom);
            logic [31:0] d = (r[6] ? 32'h1 : {24'h0, r[15:8]});
            logic stb = (r[19:17] == 3'd0);
            logic ack = (r[22:20] == 3'd0);
            cyc(sel, we, a, d, stb, r[31:24], ack, "R2-mix random");
        end

        // R1 mid-run reset
        key(8'h66, "R1 setup");
        rst_n = 1'b0;
        cyc(1'b1, 1'b0, 32'h4, 32'h0, 1'b0, 8'h0, 1'b0, "R1 mid reset");
        rst_n = 1'b1;
        chk("R1 irq low", {31'h0, irq_o}, 32'h0);
        chk("R1 rdata zero", bus_rdata, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule